// File: doc/BRIEF.md
# Card Host Status and Interrupt Unit

This block is the register front end of a memory-card host controller. It keeps the control registers that the command and data engines read (power, clock divider, command argument, command word, data timer, data length, data control) and a status word that merges sticky event flags with live FIFO levels. It also holds two interrupt masks and serves a read-only identification table at the top of a 4 KB window.

The engines report events by pulsing bits of `evt_set_i`; each pulse latches a sticky flag in status bits [10:0] until software writes a one to that bit through the clear register. The data engine drives FIFO levels on `fifo_lvl_i`, which appear live in status bits [21:11] and cannot be cleared. Each interrupt line is the OR of status ANDed with its own 32-bit mask. Offsets owned by the engines (response words, data count, FIFO count, FIFO data window) are flagged on `eng_sel_o`; their read value is taken from `eng_rdata_i`. The engines watch `we_i`, `addr_i` and `wdata_i` themselves.

Top module: `card_stat_irq`

## Requirements
- R1: A write stores the value in the addressed control register: power (0x00) and clock (0x04) keep bits [7:0], data length (0x28) keeps bits [15:0], data control (0x2C) keeps bits [7:0]; argument (0x08), command (0x0C), data timer (0x24), mask0 (0x3C) and mask1 (0x40) keep all 32 bits. Reads return the stored value, zero-extended.
- R2: A one on bit n of `evt_set_i` (n in 0..10) in a cycle makes status bit n read as one from the next cycle on, until cleared.
- R3: A write to the clear offset 0x38 clears each status bit in [10:0] whose bit is one in the written value. Status bits [21:11] always equal `fifo_lvl_i[10:0]` and are unaffected by that write. Status reads at 0x34.
- R4: If a status event bit is set by `evt_set_i` in the same cycle that a clear write names it, the bit ends set.
- R5: `irq_o[i]` is high exactly when status AND mask i is non-zero, for i = 0 and 1, following status and mask without a further register.
- R6: Reads of 0xFE0 + 4k, k = 0..7, return in bits [7:0] the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 for k = 0..7, upper bits zero; writes there change nothing.
- R7: A read of an unmapped or misaligned offset (for example 0x44 or 0x02) returns zero with `err_o` high for one cycle; a write to such an offset changes no state.
- R8: An access to 0x10..0x20, 0x30, 0x48 or 0x80..0xBC raises `eng_sel_o` in the request cycle, and a read there returns `eng_rdata_i` as sampled in that cycle.
- R9: After reset, all control, mask and status event registers read zero and both interrupts are low while `fifo_lvl_i` is zero.
- R10: `rdata_o` and `err_o` are registered: they change in the cycle after a read request and `rdata_o` holds while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | One-cycle pulse after an unmapped read |
| eng_sel_o | output | 1 | Access targets an engine-owned offset |
| eng_rdata_i | input | 32 | Read value supplied by the engines |
| evt_set_i | input | 11 | Event set pulses for status bits [10:0] |
| fifo_lvl_i | input | 11 | Live FIFO level flags for status bits [21:11] |
| irq_o | output | 2 | Level interrupts, one per mask |
| pwr_o | output | 8 | Power control register |
| clkdiv_o | output | 8 | Clock control register |
| arg_o | output | 32 | Command argument |
| cmd_o | output | 32 | Command word |
| dtimer_o | output | 32 | Data timer |
| dlen_o | output | 16 | Data length |
| dctrl_o | output | 8 | Data control |

## Verification
The status path is driven with an event pulse alone, a partial clear, a clear of every bit while FIFO levels are held high, and a set and clear landing on the same bit in one cycle; these separate sticky from live bits, a full clear from a masked one, and set priority from clear priority. The interrupt lines are watched with one mask selecting an event bit and the other a FIFO level bit, so a swapped mask or a missing bit lane shows up. Register writes use values wider than each field, which tells a correct truncation from a lost or widened one, and unmapped, misaligned and engine-owned offsets are read to check that decode gaps neither alias a real register nor alter state.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int ADDR_W  = 12;
  localparam int NUM_IRQ = 2;

  typedef enum logic [3:0] {
    RG_PWR, RG_CLK, RG_ARG, RG_CMD, RG_TMR, RG_LEN, RG_DCTL,
    RG_STAT, RG_CLR, RG_MSK0, RG_MSK1, RG_ENG, RG_ID, RG_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode(logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return RG_NONE;
    if (a >= 12'hFE0) return RG_ID;
    if (a >= 12'h080 && a <= 12'h0BC) return RG_ENG;
    if (a >= 12'h010 && a <= 12'h020) return RG_ENG;
    case (a)
      12'h000: return RG_PWR;
      12'h004: return RG_CLK;
      12'h008: return RG_ARG;
      12'h00C: return RG_CMD;
      12'h024: return RG_TMR;
      12'h028: return RG_LEN;
      12'h02C: return RG_DCTL;
      12'h030: return RG_ENG;
      12'h034: return RG_STAT;
      12'h038: return RG_CLR;
      12'h03C: return RG_MSK0;
      12'h040: return RG_MSK1;
      12'h048: return RG_ENG;
      default: return RG_NONE;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(logic [2:0] k);
    case (k)
      3'd0: return 8'h81;
      3'd1: return 8'h11;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/card_ctrl_regs.sv
module card_ctrl_regs
  import card_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PWR_W  = 8,
  parameter int LEN_W  = 16,
  parameter int DCTL_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  reg_sel_e                        sel_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [PWR_W-1:0]                pwr_o,
  output logic [PWR_W-1:0]                clkdiv_o,
  output logic [DATA_W-1:0]               arg_o,
  output logic [DATA_W-1:0]               cmd_o,
  output logic [DATA_W-1:0]               tmr_o,
  output logic [LEN_W-1:0]                len_o,
  output logic [DCTL_W-1:0]               dctrl_o,
  output logic [NUM_IRQ-1:0][DATA_W-1:0]  mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o    <= '0;
      clkdiv_o <= '0;
      arg_o    <= '0;
      cmd_o    <= '0;
      tmr_o    <= '0;
      len_o    <= '0;
      dctrl_o  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        RG_PWR:  pwr_o    <= wdata_i[PWR_W-1:0];
        RG_CLK:  clkdiv_o <= wdata_i[PWR_W-1:0];
        RG_ARG:  arg_o    <= wdata_i;
        RG_CMD:  cmd_o    <= wdata_i;
        RG_TMR:  tmr_o    <= wdata_i;
        RG_LEN:  len_o    <= wdata_i[LEN_W-1:0];
        RG_DCTL: dctrl_o  <= wdata_i[DCTL_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    localparam reg_sel_e MSEL = (i == 0) ? RG_MSK0 : RG_MSK1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    mask_o[i] <= '0;
      else if (wr_i && sel_i == MSEL) mask_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/card_status_unit.sv
module card_status_unit #(
  parameter int EVT_W = 11,
  parameter int LVL_W = 11,
  localparam int STAT_W = EVT_W + LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  set_i,
  input  logic              clr_en_i,
  input  logic [EVT_W-1:0]  clr_val_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [STAT_W-1:0] status_o
);
  logic [EVT_W-1:0] sticky_q;

  // set is OR'd after the clear so it wins on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & ~(clr_en_i ? clr_val_i : '0)) | set_i;
  end

  assign status_o = {lvl_i, sticky_q};

  p_set_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sticky_q & $past(set_i)) == $past(set_i)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && set_i == '0) |=> ((sticky_q & $past(clr_val_i)) == '0));

  p_set_beats_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && |(set_i & clr_val_i)) |=>
      ((sticky_q & $past(set_i & clr_val_i)) == $past(set_i & clr_val_i)));
endmodule

// File: rtl/card_irq_gen.sv
module card_irq_gen
  import card_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 22
) (
  input  logic [STAT_W-1:0]               status_i,
  input  logic [NUM_IRQ-1:0][DATA_W-1:0]  mask_i,
  output logic [NUM_IRQ-1:0]              irq_o
);
  logic [DATA_W-1:0] stat_ext;
  assign stat_ext = DATA_W'(status_i);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_o[i] = |(stat_ext & mask_i[i]);
  end
endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq
  import card_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 11,
  parameter int LVL_W  = 11,
  parameter int PWR_W  = 8,
  parameter int LEN_W  = 16,
  parameter int DCTL_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                err_o,
  output logic                eng_sel_o,
  input  logic [DATA_W-1:0]   eng_rdata_i,
  input  logic [EVT_W-1:0]    evt_set_i,
  input  logic [LVL_W-1:0]    fifo_lvl_i,
  output logic [NUM_IRQ-1:0]  irq_o,
  output logic [PWR_W-1:0]    pwr_o,
  output logic [PWR_W-1:0]    clkdiv_o,
  output logic [DATA_W-1:0]   arg_o,
  output logic [DATA_W-1:0]   cmd_o,
  output logic [DATA_W-1:0]   dtimer_o,
  output logic [LEN_W-1:0]    dlen_o,
  output logic [DCTL_W-1:0]   dctrl_o
);
  localparam int STAT_W = EVT_W + LVL_W;

  reg_sel_e                       sel;
  logic                           wr;
  logic                           rd;
  logic [STAT_W-1:0]              stat_w;
  logic [NUM_IRQ-1:0][DATA_W-1:0] mask_w;
  logic [DATA_W-1:0]              rd_val;
  logic                           rd_err;

  assign sel       = decode(addr_i);
  assign wr        = req_i && we_i;
  assign rd        = req_i && !we_i;
  assign eng_sel_o = req_i && (sel == RG_ENG);

  card_ctrl_regs #(
    .DATA_W(DATA_W), .PWR_W(PWR_W), .LEN_W(LEN_W), .DCTL_W(DCTL_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .pwr_o    (pwr_o),
    .clkdiv_o (clkdiv_o),
    .arg_o    (arg_o),
    .cmd_o    (cmd_o),
    .tmr_o    (dtimer_o),
    .len_o    (dlen_o),
    .dctrl_o  (dctrl_o),
    .mask_o   (mask_w)
  );

  card_status_unit #(.EVT_W(EVT_W), .LVL_W(LVL_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_set_i),
    .clr_en_i  (wr && sel == RG_CLR),
    .clr_val_i (wdata_i[EVT_W-1:0]),
    .lvl_i     (fifo_lvl_i),
    .status_o  (stat_w)
  );

  card_irq_gen #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_irq (
    .status_i (stat_w),
    .mask_i   (mask_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_val = '0;
    rd_err = 1'b0;
    case (sel)
      RG_PWR:  rd_val = DATA_W'(pwr_o);
      RG_CLK:  rd_val = DATA_W'(clkdiv_o);
      RG_ARG:  rd_val = arg_o;
      RG_CMD:  rd_val = cmd_o;
      RG_TMR:  rd_val = dtimer_o;
      RG_LEN:  rd_val = DATA_W'(dlen_o);
      RG_DCTL: rd_val = DATA_W'(dctrl_o);
      RG_STAT: rd_val = DATA_W'(stat_w);
      RG_CLR:  rd_val = '0;
      RG_MSK0: rd_val = mask_w[0];
      RG_MSK1: rd_val = mask_w[1];
      RG_ENG:  rd_val = eng_rdata_i;
      RG_ID:   rd_val = DATA_W'(id_byte(addr_i[4:2]));
      default: rd_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= rd && rd_err;
      if (rd) rdata_o <= rd_val;
    end
  end

  p_irq_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> |(DATA_W'(stat_w) & mask_w[0]));

  p_irq1_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] |-> |(DATA_W'(stat_w) & mask_w[1]));

  p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  p_err_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && !we_i));

  p_eng_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_sel_o |-> req_i);

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rdata_o));
endmodule

// File: tb/card_stat_irq_tb_top.sv
module card_stat_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        eng_sel;
  logic [31:0] eng_rdata = '0;
  logic [10:0] evt_set = '0;
  logic [10:0] fifo_lvl = '0;
  logic [1:0]  irq;
  logic [7:0]  pwr, clkdiv, dctrl;
  logic [31:0] arg, cmd, dtimer;
  logic [15:0] dlen;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  card_stat_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .eng_sel_o(eng_sel),
    .eng_rdata_i(eng_rdata), .evt_set_i(evt_set), .fifo_lvl_i(fifo_lvl),
    .irq_o(irq), .pwr_o(pwr), .clkdiv_o(clkdiv), .arg_o(arg), .cmd_o(cmd),
    .dtimer_o(dtimer), .dlen_o(dlen), .dctrl_o(dctrl)
  );

  // {addr, write value, expected readback}
  localparam logic [75:0] VEC [9] = '{
    {12'h000, 32'h0000_01FF, 32'h0000_00FF},
    {12'h004, 32'h0000_ABCD, 32'h0000_00CD},
    {12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {12'h00C, 32'h0000_0C45, 32'h0000_0C45},
    {12'h024, 32'h0012_3456, 32'h0012_3456},
    {12'h028, 32'h0001_2345, 32'h0000_2345},
    {12'h02C, 32'h0000_03FF, 32'h0000_00FF},
    {12'h03C, 32'h8000_0001, 32'h8000_0001},
    {12'h040, 32'h0000_4000, 32'h0000_4000}
  };

  localparam logic [7:0] ID_EXP [8] = '{8'h81, 8'h11, 8'h04, 8'h00,
                                        8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; e = err;
    req = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic        e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(12'h034, d, e); chk("R9 status", d, 32'h0);
    rd(12'h03C, d, e); chk("R9 mask0", d, 32'h0);
    rd(12'h000, d, e); chk("R9 power", d, 32'h0);
    chk("R9 irq", {30'b0, irq}, 32'h0);

    // R1 vector table
    foreach (VEC[i]) wr(VEC[i][75:64], VEC[i][63:32]);
    foreach (VEC[i]) begin
      rd(VEC[i][75:64], d, e);
      chk("R1 readback", d, VEC[i][31:0]);
    end
    chk("R1 dlen port", {16'b0, dlen}, 32'h0000_2345);

    // R6 identification table, also write ignored
    wr(12'hFE4, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4 * k), d, e);
      chk("R6 id byte", d, {24'b0, ID_EXP[k]});
    end

    // R2 sticky set, R5 irq via mask0 bit0
    @(negedge clk); evt_set = 11'h005;
    @(negedge clk); evt_set = '0;
    chk("R5 irq0 on event", {31'b0, irq[0]}, 32'h1);
    chk("R5 irq1 off", {31'b0, irq[1]}, 32'h0);
    repeat (2) @(negedge clk);
    rd(12'h034, d, e); chk("R2 status sticky", d, 32'h0000_0005);

    // R3 partial clear
    wr(12'h038, 32'h0000_0001);
    rd(12'h034, d, e); chk("R3 partial clear", d, 32'h0000_0004);
    chk("R5 irq0 drops", {31'b0, irq[0]}, 32'h0);

    // R3 live level bits survive full clear; R5 via mask1
    @(negedge clk); fifo_lvl = 11'h008;
    #1 chk("R5 irq1 from level", {31'b0, irq[1]}, 32'h1);
    wr(12'h038, 32'h007F_FFFF);
    rd(12'h034, d, e); chk("R3 level kept", d, 32'h0000_4000);

    // R4 set and clear in one cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h038; wdata = 32'h0000_0200; evt_set = 11'h200;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt_set = '0;
    rd(12'h034, d, e); chk("R4 set wins", d, 32'h0000_4200);
    chk("R5 irq0 masked out", {31'b0, irq[0]}, 32'h0);

    // R7 unmapped and misaligned reads, then err drops
    rd(12'h044, d, e);
    chk("R7 unmapped data", d, 32'h0);
    chk("R7 unmapped err", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R10 err one cycle", {31'b0, err}, 32'h0);
    rd(12'h002, d, e);
    chk("R7 misaligned err", {31'b0, e}, 32'h1);
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h040, d, e); chk("R7 write ignored mask1", d, 32'h0000_4000);
    rd(12'h034, d, e); chk("R7 write ignored status", d, 32'h0000_4200);
    chk("R7 no err on mapped", {31'b0, e}, 32'h0);

    // R8 engine window
    eng_rdata = 32'hCAFE_F00D;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 12'h014;
    #1 chk("R8 eng_sel", {31'b0, eng_sel}, 32'h1);
    chk("R10 rdata before edge", rdata, 32'h0000_4200);
    @(negedge clk);
    chk("R8 eng read", rdata, 32'hCAFE_F00D);
    req = 1'b0;
    eng_rdata = 32'h1234_5678;
    rd(12'h0A0, d, e); chk("R8 fifo window", d, 32'h1234_5678);
    eng_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", rdata, 32'h1234_5678);
    rd(12'h048, d, e); chk("R8 fifo count", d, 32'h0);
    chk("R8 no err", {31'b0, e}, 32'h0);

    summary();
  end
endmodule